// File: doc/BRIEF.md
# Third-Chance Clock Victim Selector

This block chooses which physical page frame to evict when a new page has to be brought in. Each frame has three status bits: a used flag, a written flag and a hidden modified flag. A clock pointer moves around the frames in circular order. Memory references report the frame they touched and whether the access was a write. Read references mark the frame used. Write references mark it both used and written.

When a victim is requested, the block raises a busy signal and examines one frame per clock cycle, starting at the pointer. Each examined frame either loses one of its chances or, if it has none left, becomes the victim. A frame that has only been read gets one extra pass. A frame that has been written gets two extra passes, and the modified flag keeps track of the fact that it needs a write-back. The block reports the victim index and the write-back flag together. It then treats the frame as refilled with a freshly loaded page, and the pointer moves on to the frame after the victim.

Top module: `tcv_selector`

## Requirements
- R1: After reset, `sel_busy` and `sel_done` are low and every frame's bits are clear. The first request therefore picks frame 0 with `sel_wb` = 0 after a single examination.
- R2: A read reference (`ref_write` = 0) accepted while idle sets the frame's used flag and leaves its written flag unchanged. A frame marked only this way is cleared on its first examination and can be chosen on the next pass, with `sel_wb` = 0.
- R3: A write reference (`ref_write` = 1) accepted while idle sets both the used and the written flags of the frame.
- R4: During a sweep, a frame whose used and written flags are both 1 keeps its written flag, loses its used flag and gets its modified flag set. A frame with exactly one of the two flags set has both cleared. A frame written before eviction is reported with `sel_wb` = 1.
- R5: The victim is the first frame, in increasing index order wrapping from FRAMES-1 to 0 and starting at the pointer, whose used and written flags are both 0 when it is examined.
- R6: After a selection, the pointer points at the frame after the victim, so the next sweep starts there (frame FRAMES-1 is followed by frame 0).
- R7: The victim is treated as refilled: its used flag is set, and its written and modified flags are cleared. It is therefore skipped once and later reported with `sel_wb` = 0 unless it is written again.
- R8: A sweep examines exactly one frame per cycle. `sel_busy` is high from the cycle after `sel_req` is accepted until the selection. `sel_done` pulses for one cycle in the first cycle where `sel_busy` is low again, so the number of busy cycles equals the number of frames examined.
- R9: A sweep ends after at most 2*FRAMES+1 examinations. When every frame has been written, it takes exactly that many and selects the frame at the starting pointer, with `sel_wb` = 1.
- R10: References and `sel_req` that arrive while `sel_busy` is high are ignored and change no frame's bits.
- R11: `sel_frame` and `sel_wb` keep their values between `sel_done` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid | input | 1 | A reference to a resident frame occurred |
| ref_frame | input | $clog2(FRAMES) | Frame index of the reference |
| ref_write | input | 1 | 1 = write reference, 0 = read reference |
| sel_req | input | 1 | Request a victim frame (accepted while idle) |
| sel_busy | output | 1 | Sweep in progress; references are ignored |
| sel_done | output | 1 | One-cycle pulse: victim outputs updated |
| sel_frame | output | $clog2(FRAMES) | Index of the chosen victim frame |
| sel_wb | output | 1 | Victim holds modified data and must be written back |

## Verification
The hardest case to reach from the ports is the worst-case sweep. In that case every frame passes through both demotions, from both flags set to written only and then to clear, before the sweep returns to the starting frame on the third revolution. The bench gets there by writing to every frame and then issuing one request. It then counts busy cycles against 2*FRAMES+1. While that long sweep is still running, the bench drives write references and a second request. A reference model of the three flags per frame, updated only when the block is idle, predicts every later victim. Any reference that slipped through during the sweep would therefore show up as a wrong frame index or a wrong write-back flag.

// File: rtl/tcv_pkg.sv
package tcv_pkg;

   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_SWEEP = 1'b1
   } sweep_state_e;

   typedef struct packed {
      logic used;
      logic written;
      logic modified;
   } frame_bits_t;

endpackage

// File: rtl/tcv_frame_slot.sv
module tcv_frame_slot
   import tcv_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        touch,
   input  logic        touch_wr,
   input  logic        scan,
   input  logic        load,
   output frame_bits_t bits
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bits <= '0;
      end else if (load) begin
         bits.used     <= 1'b1;
         bits.written  <= 1'b0;
         bits.modified <= 1'b0;
      end else if (scan) begin
         if (bits.used && bits.written) begin
            bits.used     <= 1'b0;
            bits.modified <= 1'b1;
         end else begin
            bits.used    <= 1'b0;
            bits.written <= 1'b0;
         end
      end else if (touch) begin
         bits.used <= 1'b1;
         if (touch_wr) bits.written <= 1'b1;
      end
   end

   // R4
   demote_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scan && bits.used && bits.written |=> !bits.used && bits.written && bits.modified);

   // R4
   demote_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scan && (bits.used != bits.written) |=> !bits.used && !bits.written && $stable(bits.modified));

   // R7
   refill_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> bits.used && !bits.written && !bits.modified);

   // R10
   untouched_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !touch && !scan && !load |=> $stable(bits));

endmodule

// File: rtl/tcv_sweep_ctrl.sv
module tcv_sweep_ctrl
   import tcv_pkg::*;
#(
   parameter int FRAMES = 8,
   parameter int IDX_W  = $clog2(FRAMES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_req,
   input  logic             cur_used,
   input  logic             cur_written,
   input  logic             cur_modified,
   output logic [IDX_W-1:0] ptr,
   output logic             busy,
   output logic             scan_en,
   output logic             load_en,
   output logic             sel_done,
   output logic [IDX_W-1:0] sel_frame,
   output logic             sel_wb
);

   localparam int MAX_EXAM = 2 * FRAMES + 1;
   localparam int CNT_W    = $clog2(MAX_EXAM + 1);

   sweep_state_e     state;
   logic [IDX_W-1:0] ptr_nxt;
   logic             is_free;
   logic [CNT_W-1:0] exam_cnt;

   generate
      if ((FRAMES & (FRAMES - 1)) == 0) begin : g_wrap_pow2
         assign ptr_nxt = ptr + IDX_W'(1);
      end else begin : g_wrap_cmp
         assign ptr_nxt = (ptr == IDX_W'(FRAMES - 1)) ? '0 : ptr + IDX_W'(1);
      end
   endgenerate

   assign busy    = (state == ST_SWEEP);
   assign is_free = !cur_used && !cur_written;
   assign scan_en = busy && !is_free;
   assign load_en = busy && is_free;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         ptr       <= '0;
         sel_done  <= 1'b0;
         sel_frame <= '0;
         sel_wb    <= 1'b0;
      end else begin
         sel_done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (sel_req) state <= ST_SWEEP;
            end
            ST_SWEEP: begin
               ptr <= ptr_nxt;
               if (is_free) begin
                  sel_done  <= 1'b1;
                  sel_frame <= ptr;
                  sel_wb    <= cur_modified;
                  state     <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !busy) exam_cnt <= '0;
      else                 exam_cnt <= exam_cnt + CNT_W'(1);
   end

   // R9
   sweep_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> int'(exam_cnt) < MAX_EXAM);

   // R8
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> sel_done);

   // R8
   done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_done |-> !busy);

   // R6
   ptr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_done |-> int'(ptr) == (int'(sel_frame) + 1) % FRAMES);

   // R11
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_done |-> $stable(sel_frame) && $stable(sel_wb));

endmodule

// File: rtl/tcv_selector.sv
module tcv_selector
   import tcv_pkg::*;
#(
   parameter int FRAMES = 8,
   localparam int IDX_W = $clog2(FRAMES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_valid,
   input  logic [IDX_W-1:0] ref_frame,
   input  logic             ref_write,
   input  logic             sel_req,
   output logic             sel_busy,
   output logic             sel_done,
   output logic [IDX_W-1:0] sel_frame,
   output logic             sel_wb
);

   generate
      if (FRAMES < 2) begin : g_bad_frames
         $error("tcv_selector: FRAMES must be at least 2");
      end
   endgenerate

   frame_bits_t      bits_q [FRAMES];
   logic [IDX_W-1:0] ptr;
   logic             scan_en;
   logic             load_en;
   frame_bits_t      cur;

   assign cur = bits_q[ptr];

   for (genvar i = 0; i < FRAMES; i++) begin : g_slot
      logic hit_ref;
      logic at_ptr;
      assign hit_ref = ref_valid && !sel_busy && (ref_frame == IDX_W'(i));
      assign at_ptr  = (ptr == IDX_W'(i));

      tcv_frame_slot u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .touch    (hit_ref),
         .touch_wr (ref_write),
         .scan     (scan_en && at_ptr),
         .load     (load_en && at_ptr),
         .bits     (bits_q[i])
      );
   end

   tcv_sweep_ctrl #(
      .FRAMES (FRAMES),
      .IDX_W  (IDX_W)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .sel_req      (sel_req),
      .cur_used     (cur.used),
      .cur_written  (cur.written),
      .cur_modified (cur.modified),
      .ptr          (ptr),
      .busy         (sel_busy),
      .scan_en      (scan_en),
      .load_en      (load_en),
      .sel_done     (sel_done),
      .sel_frame    (sel_frame),
      .sel_wb       (sel_wb)
   );

   // R5
   victim_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |-> !cur.used && !cur.written);

endmodule

// File: tb/tcv_selector_tb.sv
module tcv_selector_tb;

   localparam int FRAMES = 8;
   localparam int IDX_W  = $clog2(FRAMES);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             ref_valid = 1'b0;
   logic [IDX_W-1:0] ref_frame = '0;
   logic             ref_write = 1'b0;
   logic             sel_req = 1'b0;
   logic             sel_busy;
   logic             sel_done;
   logic [IDX_W-1:0] sel_frame;
   logic             sel_wb;

   int n_checks = 0;
   int n_fails  = 0;

   // reference model state
   bit m_used [FRAMES];
   bit m_wr   [FRAMES];
   bit m_mod  [FRAMES];
   int m_ptr;

   always #4 clk = ~clk;

   tcv_selector #(.FRAMES(FRAMES)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .ref_valid (ref_valid),
      .ref_frame (ref_frame),
      .ref_write (ref_write),
      .sel_req   (sel_req),
      .sel_busy  (sel_busy),
      .sel_done  (sel_done),
      .sel_frame (sel_frame),
      .sel_wb    (sel_wb)
   );

   task automatic check(input string req, input int act, input int exp, input string what);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < FRAMES; i++) begin
         m_used[i] = 0; m_wr[i] = 0; m_mod[i] = 0;
      end
      m_ptr = 0;
   endtask

   task automatic do_ref(input int f, input bit wr);
      @(negedge clk);
      ref_valid = 1'b1; ref_frame = IDX_W'(f); ref_write = wr;
      @(negedge clk);
      ref_valid = 1'b0; ref_write = 1'b0;
      m_used[f] = 1;
      if (wr) m_wr[f] = 1;
   endtask

   // predicts a sweep from the requirements; returns victim, write-back, examinations
   task automatic model_select(output int f, output bit wb, output int n);
      n = 0;
      forever begin
         n++;
         if (!m_used[m_ptr] && !m_wr[m_ptr]) begin
            f = m_ptr; wb = m_mod[m_ptr];
            m_used[m_ptr] = 1; m_wr[m_ptr] = 0; m_mod[m_ptr] = 0;
            m_ptr = (m_ptr + 1) % FRAMES;
            break;
         end else if (m_used[m_ptr] && m_wr[m_ptr]) begin
            m_used[m_ptr] = 0; m_mod[m_ptr] = 1;
         end else begin
            m_used[m_ptr] = 0; m_wr[m_ptr] = 0;
         end
         m_ptr = (m_ptr + 1) % FRAMES;
      end
   endtask

   // issues a request; optionally injects a write reference and a second request mid-sweep
   task automatic do_select(input string req, input bit inject, input int inj_frame);
      int exp_f, exp_n, cnt;
      bit exp_wb;
      model_select(exp_f, exp_wb, exp_n);
      @(negedge clk);
      sel_req = 1'b1;
      @(negedge clk);
      sel_req = 1'b0;
      cnt = 0;
      while (!sel_done && cnt < 100) begin
         if (inject && cnt == 1) begin
            ref_valid = 1'b1; ref_frame = IDX_W'(inj_frame); ref_write = 1'b1; sel_req = 1'b1;
         end else begin
            ref_valid = 1'b0; ref_write = 1'b0; sel_req = 1'b0;
         end
         @(negedge clk);
         cnt++;
      end
      ref_valid = 1'b0; ref_write = 1'b0; sel_req = 1'b0;
      check(req, int'(sel_frame), exp_f, "victim frame");
      check(req, int'(sel_wb), int'(exp_wb), "write-back flag");
      check({req, "/R8"}, cnt, exp_n, "cycles to done");
      @(negedge clk);
      check("R8", int'(sel_done), 0, "done pulse width");
      check("R11", int'(sel_frame), exp_f, "victim held after done");
   endtask

   task automatic t_reset();
      check("R1", int'(sel_busy), 0, "busy after reset");
      check("R1", int'(sel_done), 0, "done after reset");
      do_select("R1", 1'b0, 0);
   endtask

   task automatic t_pointer_advance();
      do_select("R6", 1'b0, 0);
   endtask

   task automatic t_read_skip();
      do_ref(2, 1'b0);
      do_ref(3, 1'b0);
      do_select("R2", 1'b0, 0);
   endtask

   task automatic t_write_chance();
      do_ref(5, 1'b1);
      do_select("R3", 1'b0, 0);
      do_select("R5", 1'b0, 0);
      do_select("R4", 1'b0, 0);
      do_select("R4", 1'b0, 0);
   endtask

   task automatic t_wrap_refill();
      for (int k = 0; k < 4; k++) do_select("R7", 1'b0, 0);
   endtask

   task automatic t_worst_case();
      for (int i = 0; i < FRAMES; i++) do_ref(i, 1'b1);
      do_select("R9", 1'b1, 6);
      for (int k = 0; k < 3; k++) do_select("R10", 1'b0, 0);
   endtask

   initial begin : watchdog
      #400000;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_pointer_advance();
      t_read_skip();
      t_write_chance();
      t_wrap_refill();
      t_worst_case();
      repeat (2) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

endmodule